// File: doc/BRIEF.md
# Guarded Power-Down Controller

This block owns the power-control byte register of a small microcontroller core. The CPU writes whole bytes to it over a simple write port with a register select. Power-down is entered only through a two-step unlock. First comes an arming write, and then, as the next write to this register, a commit write. Both writes take effect only while the active-low enable pin `pe_n` is held low. Once in power-down, the block stops the oscillator and closes the core clock gate. It ignores every bus access until the asynchronous hardware reset arrives.

Hardware reset returns the control state to its defaults and turns the oscillator back on. It does not touch RAM, which lies outside this block. After reset is released, a stabilization counter runs. The core is kept in reset, with its clock gated, until the oscillator has had the configured number of cycles to settle. Only then does the core run and accept writes again.

Top module: `pwrdn_guard`

## Requirements
- R1: While `rst_n` is low, the outputs are `pd_active`=0, `osc_en`=1, `core_rst`=1 and `core_clk_en`=0, without waiting for a clock edge.
- R2: After `rst_n` rises, `core_rst` stays 1 through STAB_CYCLES (default 1024) rising edges. It falls together with `core_clk_en` rising at exactly that edge.
- R3: A write to the register at select PWR_SEL with bit 1 = 1 and bit 6 = 0 arms the block. If the next write to that register has bit 6 = 1 and bit 1 = 0, the block enters power-down at that edge: `pd_active`=1, `osc_en`=0 and `core_clk_en`=0.
- R4: A commit pattern written when the block is not armed has no effect.
- R5: While armed, the next register write disarms the block if it is anything other than a valid commit. This includes a byte with both bit 1 and bit 6 set, and the value 0x00. Idle cycles without a write leave the block armed.
- R6: With `pe_n` high, an arming write does not arm the block, and a commit write does not enter power-down. A commit attempted with `pe_n` high still disarms the block.
- R7: Writes whose select differs from PWR_SEL leave the armed state unchanged.
- R8: Once in power-down, no write of any value changes the outputs. Only asserting `rst_n` exits, and it sets `osc_en` back to 1 at once.
- R9: Writes that arrive while `core_rst` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | SEL_W | Register select of the write |
| wr_data | input | 8 | Write data byte |
| pe_n | input | 1 | Power-saving enable pin, active low |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock gate enable |
| core_rst | output | 1 | Core reset, active high |
| pd_active | output | 1 | High while in power-down |

## Verification
On every cycle, the assertions check four things. Power-down never clears without reset. Power-down only starts from the armed state, with the enable pin low and the core live. The arm flag only sets with the pin low. The stabilization counter stays in range, and its ready flag never drops. The bench scenarios are needed for the behaviour that depends on order and timing. This covers the exact edge at which the core leaves reset, how each kind of intervening write disarms the block, how writes to other registers or during stabilization are ignored, and how repeated reset exits behave.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
    localparam int ARM_BIT = 1;
    localparam int CMT_BIT = 6;

    typedef enum logic [1:0] {
        WK_ARM,
        WK_COMMIT,
        WK_OTHER
    } wr_kind_e;

    typedef struct packed {
        logic armed;
        logic pd;
    } seq_state_t;

    function automatic wr_kind_e classify(input logic arm_b, input logic cmt_b);
        if (arm_b && !cmt_b)      return WK_ARM;
        else if (cmt_b && !arm_b) return WK_COMMIT;
        else                      return WK_OTHER;
    endfunction
endpackage

// File: rtl/pwrdn_stab.sv
module pwrdn_stab #(
    parameter int STAB_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int CNT_W = $clog2(STAB_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ready;
    } stab_t;

    stab_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.ready) begin
            if (s_q.cnt == LAST) s_d.ready = 1'b1;
            else                 s_d.cnt   = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ready = s_q.ready;

    // R2: once the oscillator is declared stable it stays so until reset
    p_ready_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ready |=> s_q.ready);

    // R2: the counter never runs past its terminal value
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= LAST);
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
    import pwrdn_pkg::*;
#(
    parameter int              SEL_W   = 4,
    parameter logic [SEL_W-1:0] PWR_SEL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_live,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             pe_n,
    output logic             pd
);
    seq_state_t s_d, s_q;
    wr_kind_e   kind;
    logic       hit;
    logic       unused_bits;

    assign unused_bits = ^{wr_data[7], wr_data[5:2], wr_data[0]};
    assign kind = classify(wr_data[ARM_BIT], wr_data[CMT_BIT]);
    assign hit  = wr_en && bus_live && (wr_sel == PWR_SEL);

    always_comb begin
        s_d = s_q;
        if (hit) begin
            case (kind)
                WK_ARM:    s_d.armed = !pe_n;
                WK_COMMIT: begin
                    if (s_q.armed && !pe_n) s_d.pd = 1'b1;
                    s_d.armed = 1'b0;
                end
                default:   s_d.armed = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pd = s_q.pd;

    // R8: power-down is left only through hardware reset
    p_no_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pd |=> s_q.pd);

    // R3: entry requires the armed state one cycle earlier
    p_commit_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.pd) |-> $past(s_q.armed));

    // R6: entry needs the enable pin low
    p_pe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.pd) |-> $past(!pe_n));

    // R6: arming needs the enable pin low
    p_arm_pe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.armed) |-> $past(!pe_n));

    // R9: no entry while the core is held in reset
    p_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.pd) |-> $past(bus_live));
endmodule

// File: rtl/pwrdn_guard.sv
module pwrdn_guard #(
    parameter int               SEL_W       = 4,
    parameter logic [SEL_W-1:0] PWR_SEL     = 4'h7,
    parameter int               STAB_CYCLES = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             pe_n,
    output logic             osc_en,
    output logic             core_clk_en,
    output logic             core_rst,
    output logic             pd_active
);
    logic ready;
    logic pd;
    logic bus_live;

    pwrdn_stab #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (ready)
    );

    assign bus_live = ready && !pd;

    pwrdn_seq #(.SEL_W(SEL_W), .PWR_SEL(PWR_SEL)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_live (bus_live),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .pe_n     (pe_n),
        .pd       (pd)
    );

    assign osc_en      = !pd;
    assign core_clk_en = ready && !pd;
    assign core_rst    = !ready;
    assign pd_active   = pd;
endmodule

// File: tb/pwrdn_guard_test.sv
module pwrdn_guard_test;
    localparam int         STAB = 1024;
    localparam logic [3:0] SEL  = 4'h7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       pe_n = 1'b0;
    logic       osc_en, core_clk_en, core_rst, pd_active;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pwrdn_guard #(.SEL_W(4), .PWR_SEL(SEL), .STAB_CYCLES(STAB)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pe_n(pe_n), .osc_en(osc_en),
        .core_clk_en(core_clk_en), .core_rst(core_rst), .pd_active(pd_active)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_pd(input string req, input logic exp);
        check(pd_active == exp, req, pd_active, exp);
        check(osc_en == !exp, req, osc_en, !exp);
    endtask

    // called at a negedge; returns at a negedge
    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0; wr_data = '0;
        @(negedge clk);
    endtask

    task automatic reset_and_stab();
        @(negedge clk);
        rst_n = 1'b0; #1;
        check(pd_active == 0 && osc_en == 1, "R1 pd/osc", {pd_active, osc_en}, 1);
        check(core_rst == 1 && core_clk_en == 0, "R1 core", {core_rst, core_clk_en}, 2);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        repeat (STAB - 1) @(posedge clk);
        #2 check(core_rst == 1, "R2 still held", core_rst, 1);
        @(posedge clk);
        #2 check(core_rst == 0 && core_clk_en == 1, "R2 release", {core_rst, core_clk_en}, 1);
        @(negedge clk);
    endtask

    task automatic t_entry();
        wr(SEL, 8'h02); chk_pd("R3 after arm", 0);
        wr(SEL, 8'h40); chk_pd("R3 after commit", 1);
        check(core_clk_en == 0, "R3 clk gated", core_clk_en, 0);
        repeat (5) @(negedge clk);
        wr(SEL, 8'h02); wr(SEL, 8'h40); wr(SEL, 8'hFF); wr(4'h3, 8'h00);
        chk_pd("R8 no wake", 1);
        check(core_clk_en == 0, "R8 clk stays gated", core_clk_en, 0);
        reset_and_stab();
        chk_pd("R8 exit via reset", 0);
    endtask

    task automatic t_no_arm();
        wr(SEL, 8'h40); chk_pd("R4 unarmed commit", 0);
        wr(SEL, 8'h40); chk_pd("R4 repeated commit", 0);
    endtask

    task automatic t_bad_next();
        wr(SEL, 8'h02); wr(SEL, 8'h42); wr(SEL, 8'h40);
        chk_pd("R5 both bits disarm", 0);
        wr(SEL, 8'h02); wr(SEL, 8'h00); wr(SEL, 8'h40);
        chk_pd("R5 zero disarms", 0);
        wr(SEL, 8'h02);
        repeat (20) @(negedge clk);
        wr(SEL, 8'h40);
        chk_pd("R5 idle keeps armed", 1);
        reset_and_stab();
    endtask

    task automatic t_pe_high();
        pe_n = 1'b1;
        wr(SEL, 8'h02); wr(SEL, 8'h40);
        chk_pd("R6 pin high blocks", 0);
        pe_n = 1'b0; wr(SEL, 8'h40);
        chk_pd("R6 arm ignored while high", 0);
        wr(SEL, 8'h02); pe_n = 1'b1; wr(SEL, 8'h40);
        chk_pd("R6 commit with pin high", 0);
        pe_n = 1'b0; wr(SEL, 8'h40);
        chk_pd("R6 failed commit disarmed", 0);
    endtask

    task automatic t_other_sel();
        wr(SEL, 8'h02); wr(4'h3, 8'hFF); wr(4'h0, 8'h40); wr(SEL, 8'h40);
        chk_pd("R7 other selects ignored", 1);
        reset_and_stab();
    endtask

    task automatic t_stab_writes();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        wr(SEL, 8'h02); wr(SEL, 8'h40);
        chk_pd("R9 commit during stab", 0);
        check(core_rst == 1, "R9 core held", core_rst, 1);
        wr(SEL, 8'h02);
        while (core_rst) @(negedge clk);
        wr(SEL, 8'h40);
        chk_pd("R9 arm during stab ignored", 0);
    endtask

    initial begin
        #5_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        reset_and_stab();
        t_no_arm();
        t_bad_next();
        t_pe_high();
        t_other_sel();
        t_entry();
        t_stab_writes();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule